// File: doc/BRIEF.md
# DMA Interrupt Control Register with Channel Start Gating

This block is the interrupt control register of a multi-channel DMA controller, together with the logic that decides when a channel may start. It stores per-channel interrupt enables, a master enable, a force bus-error bit and per-channel completion flags. A completion pulse from a channel sets that channel's flag if the channel's interrupt enable is set. Software clears flags by writing ones to them. Writing zero to a flag leaves it unchanged.

A read-only "request sent" bit in the top position tracks the interrupt condition. The condition is true when the master enable is set and at least one flag is set, or when the force bus-error bit is set. The block issues a single-cycle request to the interrupt controller only when this bit goes from 0 to 1. The controller therefore sees one request per episode, however many flags pile up during it.

The same block checks writes to each channel's control register. A channel starts only when the written control word has its go bit set and that channel's enable bit in the priority register is also set. A go write to a channel that is still active is reported as a start-while-busy event.

Top module: `dma_irq_ctrl`

## Requirements
- R1: While reset is held and after its release, the register reads 0, and `irq_req`, `chan_start`, `chan_active` and `start_busy` are all 0.
- R2: A register write stores bits 0..5 (spare storage), bit 15 (force bus error), bits 16..22 (channel interrupt enables, channel n at bit 16+n) and bit 23 (master enable) straight from the written value. Bits 6..14 always read 0.
- R3: Completion flags sit at bits 24..30 (channel n at bit 24+n). A write clears each flag whose written bit is 1 and leaves each flag whose written bit is 0 unchanged.
- R4: A pulse on `ch_done[n]` sets flag n only if enable bit 16+n is set after any write in the same cycle. When a clear and a completion hit the same flag in one cycle, the completion wins.
- R5: Bit 31 reads 1 exactly when (bit 23 AND any of bits 24..30) OR bit 15 holds in the register contents. Writes to bit 31 have no effect.
- R6: `irq_req` is high for exactly the one cycle in which bit 31 first reads 1 after having read 0. It stays low while bit 31 remains 1.
- R7: A control write to channel n whose bit 24 is 1 raises `chan_start[n]` for one cycle after the write, but only if bit 3+4n of `prio_en` is 1. No other write raises a start.
- R8: `chan_active[n]` is set by a control write to channel n with bit 24 = 1. It is cleared by a control write with bit 24 = 0 or by `ch_done[n]`, and a write takes precedence over a completion in the same cycle. A go write to a channel whose active bit is already set raises `start_busy` for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| icr_wr_en | input | 1 | Write strobe for the interrupt control register |
| icr_wr_data | input | 32 | Write value for the interrupt control register |
| ch_done | input | 7 | Per-channel completion pulses |
| icr_rd_data | output | 32 | Current register contents |
| irq_req | output | 1 | One-cycle request to the interrupt controller |
| ctl_wr_en | input | 1 | Write strobe for a channel control register |
| ctl_wr_ch | input | 3 | Channel addressed by the control write |
| ctl_wr_data | input | 32 | Control write value (bit 24 is go) |
| prio_en | input | 32 | Priority register contents (channel n enable at bit 3+4n) |
| chan_start | output | 7 | One-cycle start pulse per channel |
| chan_active | output | 7 | Per-channel active state |
| start_busy | output | 1 | One-cycle flag for a go write to an active channel |

## Verification
The bench builds the block with its default of seven channels, so every field position in the register is populated. It sweeps all 128 enable patterns against completion pulses, and all 128 clear patterns against a full set of flags. Every combination of master enable, bus error and pending flag is driven to reach each way the interrupt condition can start and end. Every channel is paired with full, empty, own-bit-only and all-but-own priority words. This shows that the start gate picks the correct bit 3+4n and that a busy restart is flagged.

// File: rtl/dicr_pkg.sv
// Package: field positions shared by the DMA interrupt control register
// and its channel start gate. Positions are fixed by the register layout.
package dicr_pkg;
    localparam int SPARE_LO    = 0;
    localparam int SPARE_W     = 6;
    localparam int BUSERR_BIT  = 15;
    localparam int EN_LO       = 16;
    localparam int MASTER_BIT  = 23;
    localparam int FLAG_LO     = 24;
    localparam int SENT_BIT    = 31;
    localparam int MAX_CH      = 7;
    localparam int CTL_GO_BIT  = 24;
    localparam int PRIO_STRIDE = 4;
    localparam int PRIO_EN_OFS = 3;
endpackage

// File: rtl/dicr_field.sv
// Module: dicr_field
// Holds the writable fields and the completion flags of the interrupt
// control register, and presents next-state values so the request logic
// updates on the same edge. Assumes NCH <= MAX_CH and one write per cycle.
module dicr_field
    import dicr_pkg::*;
#(
    parameter int NCH = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    input  logic [NCH-1:0]      done,
    output logic [SPARE_W-1:0]  spare_q,
    output logic                buserr_q,
    output logic [NCH-1:0]      en_q,
    output logic                master_q,
    output logic [NCH-1:0]      flags_q,
    output logic                buserr_nxt,
    output logic                master_nxt,
    output logic [NCH-1:0]      flags_nxt
);
    logic [SPARE_W-1:0] spare_nxt;
    logic [NCH-1:0]     en_nxt;
    logic [NCH-1:0]     flags_kept;
    logic               unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    // Next values: direct fields from the write, flags cleared by ones, set by enabled completions.
    always_comb begin
        spare_nxt  = wr_en ? wr_data[SPARE_LO +: SPARE_W] : spare_q;
        buserr_nxt = wr_en ? wr_data[BUSERR_BIT]          : buserr_q;
        en_nxt     = wr_en ? wr_data[EN_LO +: NCH]        : en_q;
        master_nxt = wr_en ? wr_data[MASTER_BIT]          : master_q;
        flags_kept = wr_en ? (flags_q & ~wr_data[FLAG_LO +: NCH]) : flags_q;
        flags_nxt  = flags_kept | (done & en_nxt);
    end

    // Register update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q  <= '0;
            buserr_q <= 1'b0;
            en_q     <= '0;
            master_q <= 1'b0;
            flags_q  <= '0;
        end else begin
            spare_q  <= spare_nxt;
            buserr_q <= buserr_nxt;
            en_q     <= en_nxt;
            master_q <= master_nxt;
            flags_q  <= flags_nxt;
        end
    end

    // A newly set flag must belong to an enabled channel.
    p_flag_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~$past(flags_q)) & ~en_q) == '0);

    // A flag may only drop where a one was written to it.
    p_flag_clear_w1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags_q & $past(flags_q)) &
         ~($past(wr_en) ? $past(wr_data[FLAG_LO +: NCH]) : '0)) == '0);
endmodule

// File: rtl/dicr_irq.sv
// Module: dicr_irq
// Tracks the "request sent" state from the next-state interrupt condition
// and emits a single-cycle request on its rising edge only.
// Assumes inputs are next-state values from dicr_field.
module dicr_irq #(
    parameter int NCH = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           master_nxt,
    input  logic           buserr_nxt,
    input  logic [NCH-1:0] flags_nxt,
    output logic           sent_q,
    output logic           irq_req
);
    logic cond_nxt;

    // Interrupt condition as it will stand after this edge.
    assign cond_nxt = (master_nxt && (|flags_nxt)) || buserr_nxt;

    // Sent bit follows the condition; request only on its 0-to-1 change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q  <= 1'b0;
            irq_req <= 1'b0;
        end else begin
            sent_q  <= cond_nxt;
            irq_req <= cond_nxt && !sent_q;
        end
    end

    // A request appears only in the cycle the sent bit has just risen.
    p_req_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (sent_q && !$past(sent_q)));

    // No request while the sent bit stays high.
    p_req_not_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_q && $past(sent_q)) |-> !irq_req);
endmodule

// File: rtl/dicr_start_gate.sv
// Module: dicr_start_gate
// Decides channel starts from control writes and the priority register
// enables, keeps a per-channel active bit and flags go writes to active
// channels. Assumes at most one control write per cycle.
module dicr_start_gate
    import dicr_pkg::*;
#(
    parameter int NCH = 7,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_wr_en,
    input  logic [CHW-1:0] ctl_wr_ch,
    input  logic [31:0]    ctl_wr_data,
    input  logic [31:0]    prio_en,
    input  logic [NCH-1:0] done,
    output logic [NCH-1:0] chan_start,
    output logic [NCH-1:0] chan_active,
    output logic           start_busy
);
    logic           go;
    logic [NCH-1:0] sel;
    logic [NCH-1:0] busy_hit;
    logic           unused_in_bits;

    assign go             = ctl_wr_data[CTL_GO_BIT];
    assign unused_in_bits = ^{ctl_wr_data, prio_en};

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign sel[n]      = ctl_wr_en && (ctl_wr_ch == CHW'(n));
        assign busy_hit[n] = sel[n] && go && chan_active[n];

        // Per-channel start pulse and active state; a write outranks a completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chan_start[n]  <= 1'b0;
                chan_active[n] <= 1'b0;
            end else begin
                chan_start[n] <= sel[n] && go && prio_en[PRIO_EN_OFS + PRIO_STRIDE*n];
                if (sel[n])
                    chan_active[n] <= go;
                else if (done[n])
                    chan_active[n] <= 1'b0;
            end
        end

        // A start must come from a gated go write to this channel.
        p_start_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
            chan_start[n] |-> $past(sel[n] && go && prio_en[PRIO_EN_OFS + PRIO_STRIDE*n]));
    end

    // Busy-restart flag, one cycle after the offending write.
    always_ff @(posedge clk) begin
        if (!rst_n) start_busy <= 1'b0;
        else        start_busy <= |busy_hit;
    end

    // One control write per cycle gives at most one start.
    p_start_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_start));
endmodule

// File: rtl/dma_irq_ctrl.sv
// Module: dma_irq_ctrl
// DMA interrupt control register with completion flags, one-shot request
// to the interrupt controller, and per-channel start gating.
// Assumes 1 <= NCH <= 7; unused channel field bits read 0.
module dma_irq_ctrl
    import dicr_pkg::*;
#(
    parameter int NCH = 7,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           icr_wr_en,
    input  logic [31:0]    icr_wr_data,
    input  logic [NCH-1:0] ch_done,
    output logic [31:0]    icr_rd_data,
    output logic           irq_req,
    input  logic           ctl_wr_en,
    input  logic [CHW-1:0] ctl_wr_ch,
    input  logic [31:0]    ctl_wr_data,
    input  logic [31:0]    prio_en,
    output logic [NCH-1:0] chan_start,
    output logic [NCH-1:0] chan_active,
    output logic           start_busy
);
    logic [SPARE_W-1:0] spare_q;
    logic               buserr_q, master_q, sent_q;
    logic [NCH-1:0]     en_q, flags_q, flags_nxt;
    logic               buserr_nxt, master_nxt;

    dicr_field #(.NCH(NCH)) u_field (
        .clk(clk), .rst_n(rst_n), .wr_en(icr_wr_en), .wr_data(icr_wr_data),
        .done(ch_done), .spare_q(spare_q), .buserr_q(buserr_q), .en_q(en_q),
        .master_q(master_q), .flags_q(flags_q), .buserr_nxt(buserr_nxt),
        .master_nxt(master_nxt), .flags_nxt(flags_nxt)
    );

    dicr_irq #(.NCH(NCH)) u_irq (
        .clk(clk), .rst_n(rst_n), .master_nxt(master_nxt),
        .buserr_nxt(buserr_nxt), .flags_nxt(flags_nxt),
        .sent_q(sent_q), .irq_req(irq_req)
    );

    dicr_start_gate #(.NCH(NCH)) u_gate (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_ch(ctl_wr_ch),
        .ctl_wr_data(ctl_wr_data), .prio_en(prio_en), .done(ch_done),
        .chan_start(chan_start), .chan_active(chan_active), .start_busy(start_busy)
    );

    // Assemble the read view; gaps and absent channels read 0.
    always_comb begin
        icr_rd_data = '0;
        icr_rd_data[SPARE_LO +: SPARE_W] = spare_q;
        icr_rd_data[BUSERR_BIT]          = buserr_q;
        icr_rd_data[EN_LO +: NCH]        = en_q;
        icr_rd_data[MASTER_BIT]          = master_q;
        icr_rd_data[FLAG_LO +: NCH]      = flags_q;
        icr_rd_data[SENT_BIT]            = sent_q;
    end

    // The sent bit agrees with the visible fields every cycle.
    p_sent_tracks_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
        icr_rd_data[SENT_BIT] ==
        ((icr_rd_data[MASTER_BIT] && (|icr_rd_data[30:24])) || icr_rd_data[BUSERR_BIT]));
endmodule

// File: tb/dma_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dma_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        icr_wr_en = 1'b0;
    logic [31:0] icr_wr_data = '0;
    logic [6:0]  ch_done = '0;
    logic [31:0] icr_rd_data;
    logic        irq_req;
    logic        ctl_wr_en = 1'b0;
    logic [2:0]  ctl_wr_ch = '0;
    logic [31:0] ctl_wr_data = '0;
    logic [31:0] prio_en = '0;
    logic [6:0]  chan_start, chan_active;
    logic        start_busy;

    int total = 0;
    int bad = 0;
    logic [31:0] m_icr = '0;
    logic [6:0]  m_act = '0;

    always #2.5 clk = ~clk;

    dma_irq_ctrl #(.NCH(7)) u_dut (
        .clk(clk), .rst_n(rst_n), .icr_wr_en(icr_wr_en), .icr_wr_data(icr_wr_data),
        .ch_done(ch_done), .icr_rd_data(icr_rd_data), .irq_req(irq_req),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_ch(ctl_wr_ch), .ctl_wr_data(ctl_wr_data),
        .prio_en(prio_en), .chan_start(chan_start), .chan_active(chan_active),
        .start_busy(start_busy)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Register model written from the requirements (R2..R5).
    function automatic logic [31:0] mdl_next(input logic [31:0] cur, input logic we,
                                             input logic [31:0] wd, input logic [6:0] dn);
        logic [31:0] n;
        if (we) n = (wd & 32'h00ff_803f) | (cur & 32'h7f00_0000 & ~wd);
        else    n = cur & 32'h7fff_ffff;
        n[30:24] = n[30:24] | (dn & n[22:16]);
        n[31] = (n[23] && (|n[30:24])) || n[15];
        return n;
    endfunction

    task automatic icr_cycle(input logic we, input logic [31:0] wd, input logic [6:0] dn,
                             input string req);
        logic [31:0] nx;
        logic        ereq;
        icr_wr_en = we; icr_wr_data = wd; ch_done = dn;
        nx   = mdl_next(m_icr, we, wd, dn);
        ereq = nx[31] && !m_icr[31];
        m_act = m_act & ~dn;
        m_icr = nx;
        @(posedge clk); #1;
        icr_wr_en = 1'b0; icr_wr_data = '0; ch_done = '0;
        chk(icr_rd_data == nx, req, icr_rd_data, nx);
        chk(irq_req == ereq, {req, " R6 irq_req"}, 32'(irq_req), 32'(ereq));
    endtask

    task automatic ctl_cycle(input int ch, input logic go, input logic [31:0] pr,
                             input logic [6:0] dn, input string req);
        logic [6:0] es;
        logic       eb;
        ctl_wr_en = 1'b1; ctl_wr_ch = 3'(ch); ctl_wr_data = {7'd0, go, 24'h00abcd};
        prio_en = pr; ch_done = dn;
        es = (go && pr[3 + 4*ch]) ? 7'(1 << ch) : 7'd0;
        eb = go && m_act[ch];
        m_act = m_act & ~dn;
        m_act[ch] = go;
        m_icr = mdl_next(m_icr, 1'b0, '0, dn);
        @(posedge clk); #1;
        ctl_wr_en = 1'b0; ch_done = '0;
        chk(chan_start == es, req, 32'(chan_start), 32'(es));
        chk(start_busy == eb, "R8 start_busy", 32'(start_busy), 32'(eb));
        chk(chan_active == m_act, "R8 chan_active", 32'(chan_active), 32'(m_act));
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(icr_rd_data == 0, "R1 reg in reset", icr_rd_data, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(icr_rd_data == 0, "R1 reg", icr_rd_data, 0);
        chk(irq_req == 0, "R1 irq_req", 32'(irq_req), 0);
        chk(chan_start == 0 && chan_active == 0 && start_busy == 0, "R1 gate",
            {18'd0, chan_start, chan_active}, 0);

        // R2: walking ones and all ones over the write value.
        for (int b = 0; b < 32; b++) icr_cycle(1'b1, 32'h1 << b, 7'd0, "R2 walk");
        icr_cycle(1'b1, 32'hffff_ffff, 7'd0, "R2 ones");
        icr_cycle(1'b1, 32'h7f00_0000, 7'd0, "R2 clear");

        // R4: every enable pattern against full and complementary completions.
        for (int e = 0; e < 128; e++) begin
            icr_cycle(1'b1, (32'(e) << 16) | 32'h7f00_0000, 7'd0, "R4 setup");
            icr_cycle(1'b0, '0, 7'h7f, "R4 done all");
            icr_cycle(1'b1, (32'(e) << 16) | 32'h7f00_0000, 7'(~e), "R4 clear vs done");
        end

        // R3: every clear pattern against a full set of flags.
        for (int c = 0; c < 128; c++) begin
            icr_cycle(1'b1, 32'h7f7f_0000, 7'd0, "R3 setup");
            icr_cycle(1'b0, '0, 7'h7f, "R3 fill");
            icr_cycle(1'b1, 32'h007f_0000 | (32'(c) << 24), 7'd0, "R3 w1c");
        end

        // R5/R6: master, bus error and a pending flag in every combination.
        for (int k = 0; k < 8; k++) begin
            icr_cycle(1'b1, 32'h7f7f_0000, 7'd0, "R5 setup");
            icr_cycle(1'b1, 32'h007f_0000 | (32'(k & 1) << 23) | (32'((k >> 1) & 1) << 15),
                      7'd0, "R5 cfg");
            icr_cycle(1'b0, '0, (k & 4) != 0 ? 7'h04 : 7'd0, "R5 flag");
            icr_cycle(1'b0, '0, 7'h10, "R6 more flags");
            icr_cycle(1'b0, '0, 7'd0, "R6 hold");
        end
        icr_cycle(1'b1, 32'h8000_0000, 7'd0, "R5 sent bit write ignored");
        icr_cycle(1'b1, 32'h0080_8000, 7'd0, "R6 bus error raise");
        icr_cycle(1'b1, 32'h0000_0000, 7'd0, "R5 drop");
        icr_cycle(1'b1, 32'h0080_8000, 7'd0, "R6 second episode");

        // R7: each channel against four priority words, then a no-go write.
        for (int ch = 0; ch < 7; ch++) begin
            ctl_cycle(ch, 1'b1, 32'h0, 7'd0, "R7 prio none");
            ctl_cycle(ch, 1'b0, 32'hffff_ffff, 7'd0, "R7 no go");
            ctl_cycle(ch, 1'b1, 32'h1 << (3 + 4*ch), 7'd0, "R7 own bit");
            ctl_cycle(ch, 1'b0, 32'h0, 7'd0, "R7 stop");
            ctl_cycle(ch, 1'b1, ~(32'h1 << (3 + 4*ch)), 7'd0, "R7 others only");
            ctl_cycle(ch, 1'b1, 32'hffff_ffff, 7'h7f, "R8 write beats done");
        end

        // R8: restart while active, then after completion.
        ctl_cycle(2, 1'b0, 32'hffff_ffff, 7'd0, "R8 idle");
        ctl_cycle(2, 1'b1, 32'hffff_ffff, 7'd0, "R8 first go");
        ctl_cycle(2, 1'b1, 32'hffff_ffff, 7'd0, "R8 busy go");
        icr_cycle(1'b0, '0, 7'h04, "R8 done clears active");
        chk(chan_active == m_act, "R8 active after done", 32'(chan_active), 32'(m_act));
        ctl_cycle(2, 1'b1, 32'hffff_ffff, 7'd0, "R8 go after done");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule